// File: doc/BRIEF.md
# Simple Bus Register Access Master

This block turns single register requests into transactions on a simple chip-select bus with separate read and write strobes, an address, write data, a slave ready input and read data. A requester presents an operation, an address and write data on a command port with a valid signal. While the master is idle it takes the command and drives the bus. It holds the strobes for at least one clock, and then waits for the slave to raise ready, so slaves that need wait states are supported. It returns a one-cycle response carrying the captured read data or the write completion.

A slave that never answers must not hang the requester. The master counts the cycles in which ready is sampled low. Once that count has reached the configured limit and ready is still low, the master drops the strobes and returns a response with the error flag raised. A build parameter lets the master ignore ready altogether, for slaves that always answer in one cycle. The command address is cut or zero-padded to the bus address width. Command write data narrower than the bus is zero-extended.

Comparing the returned data against expected values is up to the requester. The master carries out only one transaction at a time: no bursts, no pipelining and no queued commands.

Top module: `sbus_master`

## Requirements
- R1: After reset the outputs are quiet: `bus_cs`, `bus_rd`, `bus_wr`, `cmd_busy`, `rsp_valid` and `rsp_err` are low, and `rsp_rdata` is zero.
- R2: A command with `cmd_write`=0 (read) that is accepted on a clock edge gives, from the next cycle, `bus_cs`=1, `bus_rd`=1 and `bus_wr`=0. `bus_addr` holds the command address resized to `BUS_ADDR_W`: the low bits are kept when the bus address is narrower, and the value is zero-padded when it is wider.
- R3: A command with `cmd_write`=1 (write) gives, from the next cycle, `bus_cs`=1, `bus_wr`=1 and `bus_rd`=0, with the resized address. `bus_wdata` holds the command write data, zero-extended to `BUS_DATA_W`.
- R4: The strobes stay asserted for at least one full cycle. If ready is high on the first clock edge that ends a strobe cycle, the strobes last exactly one cycle.
- R5: With `USE_READY`=1, each strobe-cycle edge at which `bus_ready` is low extends the strobes by one cycle. `bus_addr`, `bus_wdata`, `bus_rd` and `bus_wr` stay unchanged for the whole transaction.
- R6: In the cycle after the edge that samples ready high, `bus_cs`, `bus_rd` and `bus_wr` are low and `rsp_valid` is high for exactly one cycle, with `rsp_err` low. For a read, `rsp_rdata` then holds `bus_rdata` as sampled on that edge. A write leaves `rsp_rdata` unchanged.
- R7: If ready is sampled low at `MAX_WAIT`+1 consecutive strobe edges, the strobes drop after `MAX_WAIT`+1 cycles. In the next cycle `rsp_valid` and `rsp_err` are both high for one cycle, and `rsp_rdata` keeps its previous value.
- R8: `cmd_busy` is high from the cycle after acceptance until the response cycle. A `cmd_valid` presented while `cmd_busy` is high is ignored: it does not change the bus outputs and it starts no transaction.
- R9: With `USE_READY`=0, `bus_ready` is ignored and every transaction holds the strobes for exactly one cycle and completes without error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cmd_valid | input | 1 | Command present; taken when `cmd_busy` is low |
| cmd_write | input | 1 | 1 = write, 0 = read |
| cmd_addr | input | CMD_ADDR_W | Command address |
| cmd_wdata | input | CMD_DATA_W | Command write data |
| cmd_busy | output | 1 | Transaction in progress; commands are ignored |
| rsp_valid | output | 1 | One-cycle completion pulse |
| rsp_err | output | 1 | Timeout flag, valid with `rsp_valid` |
| rsp_rdata | output | BUS_DATA_W | Data captured by the last successful read |
| bus_cs | output | 1 | Chip select |
| bus_rd | output | 1 | Read strobe |
| bus_wr | output | 1 | Write strobe |
| bus_addr | output | BUS_ADDR_W | Bus address |
| bus_wdata | output | BUS_DATA_W | Bus write data |
| bus_ready | input | 1 | Slave ready, sampled at the end of each strobe cycle |
| bus_rdata | input | BUS_DATA_W | Slave read data |

## Verification
A sequencer stuck in its active state shows at once as `bus_cs` staying high past the expected strobe length, and `cmd_busy` never falls. A wait counter that is off by one shows as a strobe one cycle too long or too short at the timeout boundary, visible on the cycle the response should appear. A read-capture enable driven at the wrong moment leaves a wrong value on `rsp_rdata` in the response cycle, because the slave drives valid data only while it signals ready. A corrupt strobe or address register shows on the bus in the first strobe cycle after acceptance.

// File: rtl/sbus_master_pkg.sv
package sbus_master_pkg;

  typedef enum logic [0:0] {
    ST_IDLE   = 1'b0,
    ST_ACTIVE = 1'b1
  } seq_state_t;

  // operation encoding on cmd_write
  localparam logic OP_READ  = 1'b0;
  localparam logic OP_WRITE = 1'b1;

endpackage

// File: rtl/sbus_req_fit.sv
// Resizes command address and write data to the bus widths.
module sbus_req_fit #(
  parameter int CMD_ADDR_W = 10,
  parameter int BUS_ADDR_W = 8,
  parameter int CMD_DATA_W = 8,
  parameter int BUS_DATA_W = 16
) (
  input  logic [CMD_ADDR_W-1:0] in_addr,
  input  logic [CMD_DATA_W-1:0] in_data,
  output logic [BUS_ADDR_W-1:0] out_addr,
  output logic [BUS_DATA_W-1:0] out_data
);

  localparam int ADDR_PAD = BUS_ADDR_W - CMD_ADDR_W;
  localparam int DATA_PAD = BUS_DATA_W - CMD_DATA_W;

  generate
    if (ADDR_PAD < 0) begin : g_addr_cut
      assign out_addr = in_addr[BUS_ADDR_W-1:0];
    end else if (ADDR_PAD == 0) begin : g_addr_same
      assign out_addr = in_addr;
    end else begin : g_addr_pad
      assign out_addr = {{ADDR_PAD{1'b0}}, in_addr};
    end

    if (DATA_PAD == 0) begin : g_data_same
      assign out_data = in_data;
    end else begin : g_data_pad
      assign out_data = {{DATA_PAD{1'b0}}, in_data};
    end
  endgenerate

endmodule

// File: rtl/sbus_wait_ctr.sv
// Counts strobe cycles in which ready was sampled low.
module sbus_wait_ctr #(
  parameter int MAX_WAIT = 4,
  parameter int CNT_W    = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic inc,
  output logic at_limit
);

  localparam logic [CNT_W-1:0] LIMIT = CNT_W'(MAX_WAIT);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  always_comb begin
    cnt_en = clr | inc;
    cnt_d  = clr ? '0 : cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  assign at_limit = (cnt_q == LIMIT);

endmodule

// File: rtl/sbus_master.sv
module sbus_master
  import sbus_master_pkg::*;
#(
  parameter int CMD_ADDR_W = 10,
  parameter int BUS_ADDR_W = 8,
  parameter int CMD_DATA_W = 8,
  parameter int BUS_DATA_W = 16,
  parameter int MAX_WAIT   = 4,
  parameter bit USE_READY  = 1'b1
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  cmd_valid,
  input  logic                  cmd_write,
  input  logic [CMD_ADDR_W-1:0] cmd_addr,
  input  logic [CMD_DATA_W-1:0] cmd_wdata,
  output logic                  cmd_busy,
  output logic                  rsp_valid,
  output logic                  rsp_err,
  output logic [BUS_DATA_W-1:0] rsp_rdata,
  output logic                  bus_cs,
  output logic                  bus_rd,
  output logic                  bus_wr,
  output logic [BUS_ADDR_W-1:0] bus_addr,
  output logic [BUS_DATA_W-1:0] bus_wdata,
  input  logic                  bus_ready,
  input  logic [BUS_DATA_W-1:0] bus_rdata
);

  localparam int WAIT_W = (MAX_WAIT < 1) ? 1 : $clog2(MAX_WAIT + 1);

  // reset: asynchronous assert, synchronous release
  logic [1:0] rst_sync_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync_q <= 2'b00;
    end else begin
      rst_sync_q <= {rst_sync_q[0], 1'b1};
    end
  end
  assign rst_int_n = rst_sync_q[1];

  // command resizing
  logic [BUS_ADDR_W-1:0] fit_addr;
  logic [BUS_DATA_W-1:0] fit_data;

  sbus_req_fit #(
    .CMD_ADDR_W(CMD_ADDR_W),
    .BUS_ADDR_W(BUS_ADDR_W),
    .CMD_DATA_W(CMD_DATA_W),
    .BUS_DATA_W(BUS_DATA_W)
  ) u_fit (
    .in_addr (cmd_addr),
    .in_data (cmd_wdata),
    .out_addr(fit_addr),
    .out_data(fit_data)
  );

  // ready source selection
  logic rdy_eff;
  generate
    if (USE_READY) begin : g_rdy_poll
      assign rdy_eff = bus_ready;
    end else begin : g_rdy_ignore
      assign rdy_eff = 1'b1;
    end
  endgenerate

  // sequencer
  seq_state_t state_q, state_d;
  logic       accept, finish_ok, finish_to, finish;
  logic       wait_inc, at_limit;

  always_comb begin
    accept    = cmd_valid && (state_q == ST_IDLE);
    finish_ok = (state_q == ST_ACTIVE) && rdy_eff;
    finish_to = (state_q == ST_ACTIVE) && !rdy_eff && at_limit;
    finish    = finish_ok || finish_to;
    wait_inc  = (state_q == ST_ACTIVE) && !rdy_eff && !at_limit;
    state_d   = state_q;
    unique case (state_q)
      ST_IDLE:   if (accept) state_d = ST_ACTIVE;
      ST_ACTIVE: if (finish) state_d = ST_IDLE;
      default:   state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      state_q <= ST_IDLE;
    end else begin
      state_q <= state_d;
    end
  end

  sbus_wait_ctr #(
    .MAX_WAIT(MAX_WAIT),
    .CNT_W   (WAIT_W)
  ) u_wait (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .clr     (accept),
    .inc     (wait_inc),
    .at_limit(at_limit)
  );

  // bus strobes and payload
  logic                  strobe_en;
  logic                  cs_d, rd_d, wr_d;
  logic                  payload_en;

  always_comb begin
    strobe_en  = accept || finish;
    payload_en = accept;
    cs_d       = accept;
    rd_d       = accept && (cmd_write == OP_READ);
    wr_d       = accept && (cmd_write == OP_WRITE);
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      bus_cs <= 1'b0;
      bus_rd <= 1'b0;
      bus_wr <= 1'b0;
    end else if (strobe_en) begin
      bus_cs <= cs_d;
      bus_rd <= rd_d;
      bus_wr <= wr_d;
    end
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      bus_addr  <= '0;
      bus_wdata <= '0;
    end else if (payload_en) begin
      bus_addr  <= fit_addr;
      bus_wdata <= fit_data;
    end
  end

  // response
  logic rdata_en;

  always_comb begin
    rdata_en = finish_ok && bus_rd;
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      rsp_valid <= 1'b0;
      rsp_err   <= 1'b0;
    end else begin
      rsp_valid <= finish;
      rsp_err   <= finish_to;
    end
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      rsp_rdata <= '0;
    end else if (rdata_en) begin
      rsp_rdata <= bus_rdata;
    end
  end

  assign cmd_busy = (state_q != ST_IDLE);

endmodule

// File: rtl/sbus_master_chk.sv
module sbus_master_chk #(
  parameter int BUS_ADDR_W = 8,
  parameter int BUS_DATA_W = 16,
  parameter bit USE_READY  = 1'b1
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  cmd_busy,
  input logic                  rsp_valid,
  input logic                  rsp_err,
  input logic                  bus_cs,
  input logic                  bus_rd,
  input logic                  bus_wr,
  input logic [BUS_ADDR_W-1:0] bus_addr,
  input logic [BUS_DATA_W-1:0] bus_wdata,
  input logic                  bus_ready
);

  // R2 / R3: exactly one strobe with chip select, none without it
  assert_one_strobe_R2: assert property (@(posedge clk) disable iff (!rst_n)
    bus_cs |-> (bus_rd ^ bus_wr));
  assert_no_stray_strobe_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_cs |-> !(bus_rd || bus_wr));

  // R4: a response only follows a cycle with strobes asserted
  assert_resp_after_strobe_R4: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> $past(bus_cs));

  // R5: payload stable across the transaction
  assert_payload_stable_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_cs && $past(bus_cs)) |-> ($stable(bus_addr) && $stable(bus_wdata) && $stable(bus_wr)));

  // R6: strobes released in response cycle, response is a single pulse
  assert_release_on_resp_R6: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> !bus_cs);
  assert_resp_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);

  // R7: the error flag only comes with a response
  assert_err_with_resp_R7: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_err |-> rsp_valid);

  // R8: busy covers the strobe cycles
  assert_busy_on_strobe_R8: assert property (@(posedge clk) disable iff (!rst_n)
    bus_cs |-> cmd_busy);

  generate
    if (USE_READY) begin : g_poll
      // R5: low ready keeps strobes up unless the timeout ends the transaction
      assert_wait_extends_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_cs && !bus_ready) |=> (bus_cs || rsp_err));
    end else begin : g_ignore
      // R9: strobes last exactly one cycle when ready is ignored
      assert_single_cycle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bus_cs) |=> !bus_cs);
      assert_no_err_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !rsp_err);
    end
  endgenerate

endmodule

bind sbus_master sbus_master_chk #(
  .BUS_ADDR_W(BUS_ADDR_W),
  .BUS_DATA_W(BUS_DATA_W),
  .USE_READY (USE_READY)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .cmd_busy (cmd_busy),
  .rsp_valid(rsp_valid),
  .rsp_err  (rsp_err),
  .bus_cs   (bus_cs),
  .bus_rd   (bus_rd),
  .bus_wr   (bus_wr),
  .bus_addr (bus_addr),
  .bus_wdata(bus_wdata),
  .bus_ready(bus_ready)
);

// File: tb/sbus_master_test.sv
module sbus_master_test;

  localparam int CAW = 10;
  localparam int BAW = 8;
  localparam int CDW = 8;
  localparam int BDW = 16;
  localparam int MW  = 4;

  typedef struct packed {
    logic           wr;
    logic [CAW-1:0] addr;
    logic [CDW-1:0] wd;
    logic [4:0]     wt;   // ready-low samples the slave inserts
    logic [3:0]     len;  // expected strobe cycles
    logic           err;  // expected timeout
  } vec_t;

  localparam int NV = 8;
  localparam vec_t VEC [NV] = '{
    '{1'b0, 10'h3A5, 8'h00, 5'd0, 4'd1, 1'b0},
    '{1'b1, 10'h012, 8'hC3, 5'd0, 4'd1, 1'b0},
    '{1'b0, 10'h1FF, 8'h00, 5'd2, 4'd3, 1'b0},
    '{1'b1, 10'h280, 8'h7E, 5'd3, 4'd4, 1'b0},
    '{1'b0, 10'h044, 8'h00, 5'd4, 4'd5, 1'b0},
    '{1'b0, 10'h155, 8'h00, 5'd5, 4'd5, 1'b1},
    '{1'b1, 10'h300, 8'hA5, 5'd9, 4'd5, 1'b1},
    '{1'b0, 10'h0F0, 8'h00, 5'd1, 4'd2, 1'b0}
  };

  logic clk;
  logic rst_n;

  // polled instance
  logic           cmd_valid, cmd_write, cmd_busy, rsp_valid, rsp_err;
  logic [CAW-1:0] cmd_addr;
  logic [CDW-1:0] cmd_wdata;
  logic [BDW-1:0] rsp_rdata, bus_wdata, bus_rdata;
  logic           bus_cs, bus_rd, bus_wr, bus_ready;
  logic [BAW-1:0] bus_addr;

  // ready-ignoring instance
  logic           n_valid, n_write, n_busy, n_rsp_valid, n_rsp_err;
  logic [CAW-1:0] n_addr;
  logic [CDW-1:0] n_wdata;
  logic [BDW-1:0] n_rsp_rdata, n_bus_wdata, n_bus_rdata;
  logic           n_cs, n_rd, n_wr;
  logic [BAW-1:0] n_bus_addr;

  int checks = 0;
  int errors = 0;

  logic [4:0] cur_wait;
  logic [4:0] hi_cnt;

  function automatic logic [BDW-1:0] slave_data(input logic [BAW-1:0] a);
    return {a ^ 8'h5A, a};
  endfunction

  initial clk = 1'b0;
  always #10 clk = ~clk;

  always @(posedge clk) begin
    if (!rst_n || !bus_cs) hi_cnt <= 5'd0;
    else                   hi_cnt <= hi_cnt + 5'd1;
  end

  assign bus_ready   = bus_cs && (hi_cnt == cur_wait);
  assign bus_rdata   = bus_ready ? slave_data(bus_addr) : 16'h0BAD;
  assign n_bus_rdata = slave_data(n_bus_addr);

  sbus_master #(
    .CMD_ADDR_W(CAW), .BUS_ADDR_W(BAW), .CMD_DATA_W(CDW),
    .BUS_DATA_W(BDW), .MAX_WAIT(MW), .USE_READY(1'b1)
  ) uut (
    .clk(clk), .rst_n(rst_n),
    .cmd_valid(cmd_valid), .cmd_write(cmd_write), .cmd_addr(cmd_addr),
    .cmd_wdata(cmd_wdata), .cmd_busy(cmd_busy),
    .rsp_valid(rsp_valid), .rsp_err(rsp_err), .rsp_rdata(rsp_rdata),
    .bus_cs(bus_cs), .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_ready(bus_ready), .bus_rdata(bus_rdata)
  );

  sbus_master #(
    .CMD_ADDR_W(CAW), .BUS_ADDR_W(BAW), .CMD_DATA_W(CDW),
    .BUS_DATA_W(BDW), .MAX_WAIT(MW), .USE_READY(1'b0)
  ) uut_nr (
    .clk(clk), .rst_n(rst_n),
    .cmd_valid(n_valid), .cmd_write(n_write), .cmd_addr(n_addr),
    .cmd_wdata(n_wdata), .cmd_busy(n_busy),
    .rsp_valid(n_rsp_valid), .rsp_err(n_rsp_err), .rsp_rdata(n_rsp_rdata),
    .bus_cs(n_cs), .bus_rd(n_rd), .bus_wr(n_wr), .bus_addr(n_bus_addr),
    .bus_wdata(n_bus_wdata), .bus_ready(1'b0), .bus_rdata(n_bus_rdata)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  logic [BDW-1:0] exp_hold;

  task automatic run_vec(input vec_t v);
    int          len;
    bit          stable_ok;
    bit          early;
    logic [BAW-1:0] a0;
    string       rq;
    cur_wait = v.wt;
    @(negedge clk);
    cmd_valid = 1'b1; cmd_write = v.wr; cmd_addr = v.addr; cmd_wdata = v.wd;
    @(negedge clk);
    cmd_valid = 1'b0;
    rq = v.wr ? "R3" : "R2";
    chk(bus_cs && (bus_rd == !v.wr) && (bus_wr == v.wr), rq, "strobes",
        {29'd0, bus_cs, bus_rd, bus_wr}, {29'd0, 1'b1, !v.wr, v.wr});
    chk(bus_addr == v.addr[BAW-1:0], "R2", "resized address",
        32'(bus_addr), 32'(v.addr[BAW-1:0]));
    if (v.wr)
      chk(bus_wdata == {8'h00, v.wd}, "R3", "zero-extended wdata",
          32'(bus_wdata), 32'({8'h00, v.wd}));
    chk(cmd_busy, "R8", "busy during transaction", 32'(cmd_busy), 32'd1);
    len = 0; stable_ok = 1'b1; early = 1'b0; a0 = bus_addr;
    while (bus_cs && len < 20) begin
      len++;
      if (bus_addr != a0 || bus_wr != v.wr) stable_ok = 1'b0;
      if (rsp_valid) early = 1'b1;
      @(negedge clk);
    end
    rq = v.err ? "R7" : ((v.wt == 0) ? "R4" : "R5");
    chk(len == int'(v.len), rq, "strobe length", 32'(len), 32'(v.len));
    chk(stable_ok && !early, "R5", "payload stable, no early response",
        {30'd0, stable_ok, early}, 32'd2);
    rq = v.err ? "R7" : "R6";
    chk(rsp_valid && (rsp_err == v.err) && !bus_rd && !bus_wr, rq, "response flags",
        {29'd0, rsp_valid, rsp_err, bus_rd | bus_wr}, {29'd0, 1'b1, v.err, 1'b0});
    if (!v.wr && !v.err) exp_hold = slave_data(v.addr[BAW-1:0]);
    chk(rsp_rdata == exp_hold, rq, "response data", 32'(rsp_rdata), 32'(exp_hold));
    chk(!cmd_busy, "R8", "idle in response cycle", 32'(cmd_busy), 32'd0);
    @(negedge clk);
    chk(!rsp_valid && !rsp_err, "R6", "single-cycle response",
        {30'd0, rsp_valid, rsp_err}, 32'd0);
  endtask

  task automatic run_nr(input logic wr, input logic [CAW-1:0] a, input logic [CDW-1:0] d);
    @(negedge clk);
    n_valid = 1'b1; n_write = wr; n_addr = a; n_wdata = d;
    @(negedge clk);
    n_valid = 1'b0;
    chk(n_cs && (n_wr == wr), "R9", "strobe with ready ignored",
        {30'd0, n_cs, n_wr}, {30'd0, 1'b1, wr});
    @(negedge clk);
    chk(!n_cs && n_rsp_valid && !n_rsp_err, "R9", "one-cycle completion, no error",
        {29'd0, n_cs, n_rsp_valid, n_rsp_err}, 32'd2);
    if (!wr)
      chk(n_rsp_rdata == slave_data(a[BAW-1:0]), "R9", "read data",
          32'(n_rsp_rdata), 32'(slave_data(a[BAW-1:0])));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: run did not finish");
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    cmd_valid = 1'b0; cmd_write = 1'b0; cmd_addr = '0; cmd_wdata = '0;
    n_valid = 1'b0; n_write = 1'b0; n_addr = '0; n_wdata = '0;
    cur_wait = 5'd0;
    exp_hold = '0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1 reset state
    chk(!bus_cs && !bus_rd && !bus_wr, "R1", "strobes after reset",
        {29'd0, bus_cs, bus_rd, bus_wr}, 32'd0);
    chk(!cmd_busy && !rsp_valid && !rsp_err, "R1", "status after reset",
        {29'd0, cmd_busy, rsp_valid, rsp_err}, 32'd0);
    chk(rsp_rdata == '0, "R1", "read data after reset", 32'(rsp_rdata), 32'd0);

    // table of transactions
    for (int i = 0; i < NV; i++) run_vec(VEC[i]);

    // R8: command during busy ignored
    cur_wait = 5'd2;
    @(negedge clk);
    cmd_valid = 1'b1; cmd_write = 1'b0; cmd_addr = 10'h066; cmd_wdata = '0;
    @(negedge clk);
    cmd_write = 1'b1; cmd_addr = 10'h0AA; cmd_wdata = 8'h11;
    @(negedge clk);
    cmd_valid = 1'b0;
    chk(bus_addr == 8'h66 && bus_rd && !bus_wr, "R8", "bus unchanged by busy command",
        {23'd0, bus_addr, bus_rd}, {23'd0, 8'h66, 1'b1});
    @(negedge clk);
    chk(bus_cs && bus_addr == 8'h66, "R8", "still first transaction",
        {23'd0, bus_addr, bus_cs}, {23'd0, 8'h66, 1'b1});
    @(negedge clk);
    exp_hold = slave_data(8'h66);
    chk(rsp_valid && rsp_rdata == exp_hold, "R8", "first transaction completes",
        32'(rsp_rdata), 32'(exp_hold));
    @(negedge clk);
    chk(!bus_cs && !cmd_busy, "R8", "ignored command started nothing",
        {30'd0, bus_cs, cmd_busy}, 32'd0);

    // R9 ready ignored
    run_nr(1'b0, 10'h2C7, 8'h00);
    run_nr(1'b1, 10'h031, 8'h9E);

    repeat (2) @(negedge clk);
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule